// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block forms the data-memory address for an indirect or direct load or store. The three 16-bit pointer registers (X, Y, Z) belong to the register file outside the block. The block reads their current values on input ports. One start strobe, together with an operation code, picks the pointer and the addressing mode. The block then issues one memory request with a read/write qualifier. One cycle later it reports completion and, where the mode updates the pointer, gives the new pointer value for the register file to write back.

There are five modes. Plain indirect addresses memory with the pointer as it is. Post-increment accesses at the pointer and then writes back the pointer plus one. Pre-decrement subtracts one first and uses the result both as the address and as the write-back value. Displacement adds an unsigned 6-bit offset to Y or Z and leaves the pointer untouched. Direct mode uses a 16-bit constant from the instruction and no pointer at all. All arithmetic wraps modulo 65536. Every accepted operation takes exactly two cycles, and the block raises no status flags.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset, mem_req, done, wb_en and busy are all 0.
- R2: When start is accepted on a clock edge, mem_req is 1 for exactly the following cycle and done is 1 for exactly the cycle after that. busy is 1 during both of those cycles and 0 otherwise.
- R3: Mode code 0 (plain) puts the selected pointer on mem_addr and produces no write-back (wb_en stays 0). Pointer code 0 selects X, 1 selects Y and 2 selects Z.
- R4: Mode code 1 (post-increment) puts the selected pointer on mem_addr. In the done cycle it drives wb_en=1, wb_ptr set to the pointer code, and wb_val equal to the pointer plus one modulo 65536.
- R5: Mode code 2 (pre-decrement) puts the pointer minus one modulo 65536 on mem_addr. In the done cycle it drives wb_en=1 and the same value on wb_val.
- R6: Mode code 3 (displacement) puts the Y or Z pointer plus the zero-extended 6-bit disp, modulo 65536, on mem_addr, with no write-back.
- R7: A start with an illegal combination is ignored: busy, mem_req and done stay 0. The illegal combinations are displacement on X (pointer code 0), pointer code 3 with modes 0 to 3, and mode codes 5 to 7.
- R8: Mode code 4 (direct) puts the konst input on mem_addr whatever the pointer code, with no write-back.
- R9: mem_we during the request cycle equals the op_store value given with the accepted start.
- R10: A start that arrives while busy is 1 is ignored and does not alter the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| op_mode | input | 3 | 0 plain, 1 post-inc, 2 pre-dec, 3 displacement, 4 direct |
| op_ptr | input | 2 | 0 X, 1 Y, 2 Z |
| op_store | input | 1 | 1 for a store, 0 for a load |
| disp | input | 6 | Unsigned displacement |
| konst | input | 16 | Direct address |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Effective address |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_ptr | output | 2 | Pointer to write back |
| wb_val | output | 16 | New pointer value |
| done | output | 1 | Operation completes |
| busy | output | 1 | Operation in progress |

## Verification
The request with its address and write qualifier is due one cycle after the edge that accepts start. Done and any write-back are due one cycle after that. The bench keeps a behavioural model that advances on the same edges, and it compares every output at the falling edge, when the new values have settled. Address and write-back values are compared only in the cycles where their strobes are due. Wrap-around at 0 and 65535, displacement past the top of memory, illegal codes and a start held high through an operation are all driven explicitly, and then random traffic follows.

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_mode,
  input  logic [1:0]    op_ptr,
  input  logic          op_store,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] konst,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          wb_en,
  output logic [1:0]    wb_ptr,
  output logic [AW-1:0] wb_val,
  output logic          done,
  output logic          busy
);
  localparam logic [2:0] M_PLAIN = 3'd0, M_POST = 3'd1, M_PRE = 3'd2,
                         M_DISP = 3'd3, M_DIR = 3'd4;

  logic          ph_acc, ph_fin;
  logic [AW-1:0] addr_q, wbv_q;
  logic          we_q, upd_q;
  logic [1:0]    sel_q;
  logic [AW-1:0] pval, addr_d, wbv_d;
  logic          legal, accept;

  always_comb begin
    case (op_ptr)
      2'd0:    pval = ptr_x;
      2'd1:    pval = ptr_y;
      default: pval = ptr_z;
    endcase
  end

  always_comb begin
    case (op_mode)
      M_PLAIN, M_POST: legal = (op_ptr != 2'd3);
      M_PRE:           legal = (op_ptr != 2'd3);
      M_DISP:          legal = (op_ptr == 2'd1) || (op_ptr == 2'd2);
      M_DIR:           legal = 1'b1;
      default:         legal = 1'b0;
    endcase
  end

  always_comb begin
    case (op_mode)
      M_PRE:   addr_d = pval - 1'b1;
      M_DISP:  addr_d = pval + AW'(disp);
      M_DIR:   addr_d = konst;
      default: addr_d = pval;
    endcase
  end

  assign wbv_d  = (op_mode == M_POST) ? pval + 1'b1 : pval - 1'b1;
  assign busy   = ph_acc | ph_fin;
  assign accept = start & ~busy & legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_acc <= 1'b0;
      ph_fin <= 1'b0;
      addr_q <= '0;
      wbv_q  <= '0;
      we_q   <= 1'b0;
      upd_q  <= 1'b0;
      sel_q  <= 2'd0;
    end else begin
      ph_acc <= accept;
      ph_fin <= ph_acc;
      if (accept) begin
        addr_q <= addr_d;
        wbv_q  <= wbv_d;
        we_q   <= op_store;
        upd_q  <= (op_mode == M_POST) || (op_mode == M_PRE);
        sel_q  <= op_ptr;
      end
    end
  end

  assign mem_req  = ph_acc;
  assign mem_we   = ph_acc & we_q;
  assign mem_addr = addr_q;
  assign done     = ph_fin;
  assign wb_en    = ph_fin & upd_q;
  assign wb_ptr   = sel_q;
  assign wb_val   = wbv_q;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !mem_req && !done && !wb_en && !busy);
  a_r2_req_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> done && !mem_req);
  a_r2_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req));
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, done}));
  a_r4_r5_wb_value: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_val == $past(mem_addr)) || (wb_val == $past(mem_addr) + 1'b1));
  a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> 1'b0);
  a_r9_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
endmodule

// File: tb/tb_ptr_addr_gen.sv
module tb_ptr_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_store = 1'b0;
  logic [2:0] op_mode = '0;
  logic [1:0] op_ptr = '0;
  logic [5:0] disp = '0;
  logic [15:0] konst = '0, px = '0, py = '0, pz = '0;
  logic mem_req, mem_we, wb_en, done, busy;
  logic [15:0] mem_addr, wb_val;
  logic [1:0] wb_ptr;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  ptr_addr_gen dut (.clk, .rst_n, .start, .op_mode, .op_ptr, .op_store, .disp,
    .konst, .ptr_x(px), .ptr_y(py), .ptr_z(pz), .mem_req, .mem_we, .mem_addr,
    .wb_en, .wb_ptr, .wb_val, .done, .busy);

  int phase = 0;
  int e_addr, e_wbv, e_sel;
  bit e_we, e_upd;
  string tag = "R1";
  int stores[int];

  function automatic int pget(int s);
    return (s == 0) ? int'(px) : (s == 1) ? int'(py) : int'(pz);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; tag = "R1";
    end else if (phase == 1) begin
      if (e_we) stores[e_addr] = e_addr;
      phase = 2;
    end else if (phase == 2) begin
      if (e_upd) begin
        if (e_sel == 0) px <= 16'(e_wbv);
        else if (e_sel == 1) py <= 16'(e_wbv);
        else pz <= 16'(e_wbv);
      end
      phase = 0;
    end else if (start) begin
      int p, m;
      bit ok;
      p = pget(op_ptr);
      m = op_mode;
      ok = (m == 4) || (m <= 2 && op_ptr != 3) || (m == 3 && (op_ptr == 1 || op_ptr == 2));
      if (ok) begin
        e_sel = op_ptr; e_we = op_store; e_upd = (m == 1 || m == 2);
        case (m)
          0: begin e_addr = p; tag = "R3"; end
          1: begin e_addr = p; e_wbv = (p + 1) % 65536; tag = "R4"; end
          2: begin e_addr = (p + 65535) % 65536; e_wbv = e_addr; tag = "R5"; end
          3: begin e_addr = (p + disp) % 65536; tag = "R6"; end
          default: begin e_addr = konst; tag = "R8"; end
        endcase
        phase = 1;
      end else tag = "R7";
    end
  end

  task automatic chk(string t, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", t, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk({tag, "/R2 busy"}, busy, phase != 0);
    chk({tag, "/R2 mem_req"}, mem_req, phase == 1);
    chk({tag, "/R2 done"}, done, phase == 2);
    chk({tag, " wb_en"}, wb_en, phase == 2 && e_upd);
    if (phase == 1) begin
      chk({tag, " mem_addr"}, mem_addr, e_addr);
      chk("R9 mem_we", mem_we, e_we);
    end
    if (phase == 2 && e_upd) begin
      chk({tag, " wb_val"}, wb_val, e_wbv);
      chk({tag, " wb_ptr"}, wb_ptr, e_sel);
    end
  endtask

  task automatic step(bit s, int m, int p, bit w, int q, int k);
    @(negedge clk);
    compare();
    start = s; op_mode = 3'(m); op_ptr = 2'(p); op_store = w;
    disp = 6'(q); konst = 16'(k);
  endtask

  task automatic op(int m, int p, bit w, int q, int k);
    step(1, m, p, w, q, k);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    px = 16'h0000; py = 16'hFFF0; pz = 16'hFFFF;
    repeat (3) step(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0);          // R3 plain X
    op(2, 0, 1, 0, 0);          // R5 X wraps 0 -> FFFF
    op(1, 2, 0, 0, 0);          // R4 Z wraps FFFF -> 0
    op(3, 1, 1, 63, 0);         // R6 Y+63 wraps
    op(3, 2, 0, 5, 0);          // R6 Z displacement
    op(3, 0, 1, 7, 0);          // R7 displacement on X rejected
    op(0, 3, 0, 0, 0);          // R7 pointer code 3 rejected
    op(6, 1, 0, 0, 0);          // R7 mode 6 rejected
    op(4, 3, 1, 0, 16'hBEEF);   // R8 direct ignores pointer code
    op(1, 1, 0, 0, 0);          // R4 Y post-inc
    for (int i = 0; i < 9; i++) step(1, 1, 0, i[0], 0, 0);  // R10 held start
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 63), $urandom);
    step(0, 0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule